// File: doc/BRIEF.md
# Windowed Watchdog Timer with Register Bus

The block is a software-serviced watchdog that sits on a 32-bit register bus. Once enabled, a down-counter runs from a programmed time-out value. Software must reload it by writing a two-word key pair to the service register. If the counter reaches zero, the block either requests a system reset at once, or first raises an interrupt and requests the reset only at the next expiry. When window mode is on, a reload that comes too early is rejected, so both a stuck program and a program that runs away are caught.

Mode inputs decide whether the count keeps moving or holds. A debug halt holds it when the freeze bit is set. Low-power stop holds it when the stop bit is set. Standby always holds it. Every bus request is screened, and a request that breaks the access rules changes no state. Depending on one control bit, such a request is answered with a bus error or with a system reset request. A soft lock makes the configuration registers read-only until an unlock key pair is written. A hard lock does the same and only a reset clears it.

Top module: `bus_watchdog`

## Requirements
- R1: After reset: control reads 0, the time-out and counter registers read TIMEOUT_RST (default 0x400), the interrupt flag reads 0, and irq_o, rst_req_o and err_o are low.
- R2: Registers are decoded by byte offset: 0x00 control, 0x04 interrupt, 0x08 time-out, 0x0C window, 0x10 service (reads 0), 0x14 counter (read-only). Every request gets rvalid_o one cycle later, with rdata_o holding the read value.
- R3: A request is invalid if any of these holds: perm_i is low, size_i is not 2'b10 (word; 2'b00 is byte, 2'b01 is half), the offset is not word-aligned or is 0x18 or above, or it writes the counter register. An invalid request changes nothing and returns rdata_o = 0. When control bit 7 is 0, it also gets err_o = 1.
- R4: When control bit 7 (reset-on-invalid) is 1, an invalid request raises rst_req_o for one cycle in place of err_o.
- R5: While control bit 0 (enable) is 0, the counter tracks the time-out register. Once enabled, it decrements by one per clock, so that expiry comes T+1 cycles after enabling with time-out T. At each expiry the counter reloads from the time-out register.
- R6: With control bit 5 at 0, every expiry raises rst_req_o for one cycle.
- R7: With control bit 5 at 1, an expiry while the interrupt flag (interrupt register bit 0, also on irq_o) is clear sets the flag and raises no reset. An expiry while the flag is set raises rst_req_o. Writing 1 to bit 0 clears the flag.
- R8: Writing SVC_KEY_A (0xC3A5) and then SVC_KEY_B (0x5A3C) to the service register reloads the counter. While enabled, a service value that is none of the four keys is invalid. While disabled, such a value is ignored.
- R9: With control bit 6 (window mode) set and the block enabled, completing a service pair while the counter is greater than or equal to the window register is invalid and does not reload.
- R10: The counter holds when dbg_halt_i is high and control bit 1 is set, or when stop_i is high and control bit 2 is set, or whenever standby_i is high. With bit 2 clear, it keeps running in stop mode.
- R11: Control bit 3 (soft lock) makes control, time-out and window read-only, and writes to them become invalid. Writing UNL_KEY_A (0x9E17) and then UNL_KEY_B (0x71E9) to the service register clears the soft lock.
- R12: Control bit 4 (hard lock) locks the same registers. It stays set until reset, and the unlock pair does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Byte offset |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| wdata_i | input | 32 | Write data |
| perm_i | input | 1 | Requesting master is permitted |
| dbg_halt_i | input | 1 | Processor halted for debug |
| stop_i | input | 1 | Low-power stop mode |
| standby_i | input | 1 | Standby mode |
| rvalid_o | output | 1 | Response valid |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Bus error response |
| irq_o | output | 1 | Interrupt flag |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench measures the exact number of cycles from enabling or servicing the block to the reset request. A counter that is off by one in its period, or that reloads at the wrong point, shows up as a cycle mismatch. It services once before the window opens and once after, and checks that the early attempt fails while the late one moves the expiry. A design that compared against the wrong bound would either reject both attempts or accept both. It holds the counter under each mode input and reads the count back to confirm it has not moved. It also checks that a soft lock is undone by the unlock pair while a hard lock is not. A design that mixed up the two lock bits would leave the configuration writable, or leave it locked, at the wrong time.

// File: rtl/bus_watchdog_pkg.sv
package bus_watchdog_pkg;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_IRQ, SEL_TO, SEL_WIN, SEL_SVC, SEL_CNT, SEL_NONE
  } reg_sel_e;

  typedef struct packed {
    logic ria;  // 7: invalid access -> reset
    logic wnd;  // 6: window mode
    logic itr;  // 5: interrupt before reset
    logic hlk;  // 4: hard lock
    logic slk;  // 3: soft lock
    logic stp;  // 2: hold in stop
    logic frz;  // 1: hold in debug halt
    logic en;   // 0: enable
  } ctrl_t;
endpackage

// File: rtl/wdt_access_check.sv
module wdt_access_check
  import bus_watchdog_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          perm_i,
  input  logic          locked_i,
  output reg_sel_e      sel_o,
  output logic          bad_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      case (addr_i[AW-1:2])
        (AW-2)'(0): sel_o = SEL_CTRL;
        (AW-2)'(1): sel_o = SEL_IRQ;
        (AW-2)'(2): sel_o = SEL_TO;
        (AW-2)'(3): sel_o = SEL_WIN;
        (AW-2)'(4): sel_o = SEL_SVC;
        (AW-2)'(5): sel_o = SEL_CNT;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end

  logic cfg_sel;
  assign cfg_sel = (sel_o == SEL_CTRL) || (sel_o == SEL_TO) || (sel_o == SEL_WIN);

  assign bad_o = req_i && (!perm_i || (size_i != SIZE_WORD) || (sel_o == SEL_NONE)
                           || (we_i && (sel_o == SEL_CNT))
                           || (we_i && locked_i && cfg_sel));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
  parameter int          DW        = 32,
  parameter logic [31:0] SVC_KEY_A = 32'h0000_C3A5,
  parameter logic [31:0] SVC_KEY_B = 32'h0000_5A3C,
  parameter logic [31:0] UNL_KEY_A = 32'h0000_9E17,
  parameter logic [31:0] UNL_KEY_B = 32'h0000_71E9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  input  logic          en_i,
  input  logic          wnd_i,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] window_i,
  output logic          bad_o,
  output logic          reload_o,
  output logic          unlock_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_SVC, ST_UNL} seq_e;
  seq_e state_q, state_d;

  logic is_key, early;
  assign is_key = (data_i == DW'(SVC_KEY_A)) || (data_i == DW'(SVC_KEY_B)) ||
                  (data_i == DW'(UNL_KEY_A)) || (data_i == DW'(UNL_KEY_B));
  assign early  = en_i && wnd_i && (count_i >= window_i);

  always_comb begin
    state_d  = state_q;
    bad_o    = 1'b0;
    reload_o = 1'b0;
    unlock_o = 1'b0;
    if (wr_i) begin
      state_d = ST_IDLE;
      if (!is_key) bad_o = en_i;
      else if (data_i == DW'(SVC_KEY_A)) state_d = ST_SVC;
      else if (data_i == DW'(UNL_KEY_A)) state_d = ST_UNL;
      else if (data_i == DW'(SVC_KEY_B) && state_q == ST_SVC) begin
        if (early) bad_o = 1'b1;
        else reload_o = 1'b1;
      end else if (data_i == DW'(UNL_KEY_B) && state_q == ST_UNL) unlock_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R8
  reload_after_key_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> (state_q == ST_SVC));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int          DW          = 32,
  parameter logic [31:0] TIMEOUT_RST = 32'h0000_0400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          run_i,
  input  logic          itr_i,
  input  logic          reload_i,
  input  logic          clr_flag_i,
  input  logic [DW-1:0] timeout_i,
  output logic [DW-1:0] count_o,
  output logic          flag_o,
  output logic          expire_rst_o
);
  logic [DW-1:0] count_q;
  logic          flag_q, expire;

  assign expire       = en_i && run_i && !reload_i && (count_q == '0);
  assign expire_rst_o = expire && !(itr_i && !flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= DW'(TIMEOUT_RST);
      flag_q  <= 1'b0;
    end else begin
      if (!en_i || reload_i || expire) count_q <= timeout_i;
      else if (run_i)                  count_q <= count_q - 1'b1;
      if (expire && itr_i && !flag_q)  flag_q <= 1'b1;
      else if (clr_flag_i)             flag_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;

  // R10
  halted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_i && !reload_i) |=> $stable(count_q));
  // R7
  itr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && itr_i && !flag_q) |=> flag_q);
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bus_watchdog_pkg::*;
#(
  parameter int          AW          = 14,
  parameter int          DW          = 32,
  parameter logic [31:0] TIMEOUT_RST = 32'h0000_0400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          perm_i,
  input  logic          dbg_halt_i,
  input  logic          stop_i,
  input  logic          standby_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  localparam int CW = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic [DW-1:0] timeout_q, window_q, count, rdata_d;
  reg_sel_e      sel;
  logic          base_bad, svc_bad, reload, unlock, inv, flag, expire_rst, run;
  logic          ok_wr, rvalid_q, err_q, rst_q;
  logic [DW-1:0] rdata_q;

  wdt_access_check #(.AW(AW)) u_chk (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .size_i(size_i), .perm_i(perm_i),
    .locked_i(ctrl_q.slk || ctrl_q.hlk), .sel_o(sel), .bad_o(base_bad)
  );

  wdt_key_seq #(.DW(DW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(req_i && we_i && !base_bad && (sel == SEL_SVC)),
    .data_i(wdata_i), .en_i(ctrl_q.en), .wnd_i(ctrl_q.wnd),
    .count_i(count), .window_i(window_q),
    .bad_o(svc_bad), .reload_o(reload), .unlock_o(unlock)
  );

  assign inv   = base_bad || svc_bad;
  assign ok_wr = req_i && we_i && !inv;
  assign run   = ctrl_q.en && !standby_i && !(dbg_halt_i && ctrl_q.frz)
                 && !(stop_i && ctrl_q.stp);

  wdt_countdown #(.DW(DW), .TIMEOUT_RST(TIMEOUT_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl_q.en), .run_i(run), .itr_i(ctrl_q.itr),
    .reload_i(reload), .clr_flag_i(ok_wr && (sel == SEL_IRQ) && wdata_i[0]),
    .timeout_i(timeout_q), .count_o(count), .flag_o(flag), .expire_rst_o(expire_rst)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: rdata_d = DW'(ctrl_q);
      SEL_IRQ:  rdata_d = DW'(flag);
      SEL_TO:   rdata_d = timeout_q;
      SEL_WIN:  rdata_d = window_q;
      SEL_CNT:  rdata_d = count;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      timeout_q <= DW'(TIMEOUT_RST);
      window_q  <= '0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      if (ok_wr && sel == SEL_CTRL) begin
        ctrl_q     <= ctrl_t'(wdata_i[CW-1:0]);
        ctrl_q.hlk <= wdata_i[4] || ctrl_q.hlk;
      end else if (unlock) begin
        ctrl_q.slk <= 1'b0;
      end
      if (ok_wr && sel == SEL_TO)  timeout_q <= wdata_i;
      if (ok_wr && sel == SEL_WIN) window_q  <= wdata_i;
      rvalid_q <= req_i;
      rdata_q  <= (req_i && !we_i && !inv) ? rdata_d : '0;
      err_q    <= req_i && inv && !ctrl_q.ria;
      rst_q    <= expire_rst || (req_i && inv && ctrl_q.ria);
    end
  end

  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign irq_o     = flag;
  assign rst_req_o = rst_q;

  // R3
  bad_access_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && inv && !ctrl_q.ria) |=> (err_o && rdata_o == '0));
  // R4
  ria_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && inv && ctrl_q.ria) |=> (rst_req_o && !err_o));
  // R12
  hlk_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.hlk |=> ctrl_q.hlk);
  // R2
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
endmodule

// File: tb/test_bus_watchdog.sv
`timescale 1ns/1ps
module test_bus_watchdog;
  localparam logic [31:0] TO_RST = 32'h400;
  localparam logic [13:0] A_CTRL = 14'h00, A_IRQ = 14'h04, A_TO = 14'h08,
                          A_WIN = 14'h0C, A_SVC = 14'h10, A_CNT = 14'h14;
  localparam logic [31:0] KA = 32'hC3A5, KB = 32'h5A3C, UA = 32'h9E17, UB = 32'h71E9;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, perm = 1, dbg = 0, stp = 0, sby = 0;
  logic [13:0] addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic rvalid, err, irq, rstreq;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  logic s_err, s_rst;
  logic [31:0] s_rd;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_watchdog i_bus_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .perm_i(perm), .dbg_halt_i(dbg), .stop_i(stp), .standby_i(sby),
    .rvalid_o(rvalid), .rdata_o(rdata), .err_o(err), .irq_o(irq), .rst_req_o(rstreq)
  );

  typedef struct packed {
    logic        w;
    logic [13:0] a;
    logic [1:0]  sz;
    logic [31:0] d;
    logic        e;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A_TO,  2'd2, 32'h64,   1'b0, 32'h0},
    '{1'b0, A_TO,  2'd2, 32'h0,    1'b0, 32'h64},
    '{1'b0, A_CNT, 2'd2, 32'h0,    1'b0, 32'h64},
    '{1'b1, A_WIN, 2'd2, 32'hA,    1'b0, 32'h0},
    '{1'b0, A_WIN, 2'd2, 32'h0,    1'b0, 32'hA},
    '{1'b1, A_CNT, 2'd2, 32'h5,    1'b1, 32'h0},
    '{1'b0, A_CNT, 2'd2, 32'h0,    1'b0, 32'h64},
    '{1'b1, A_TO,  2'd0, 32'h7,    1'b1, 32'h0},
    '{1'b0, A_TO,  2'd1, 32'h0,    1'b1, 32'h0},
    '{1'b0, A_TO,  2'd2, 32'h0,    1'b0, 32'h64},
    '{1'b0, 14'h18, 2'd2, 32'h0,   1'b1, 32'h0},
    '{1'b0, 14'h06, 2'd2, 32'h0,   1'b1, 32'h0},
    '{1'b1, A_IRQ, 2'd2, 32'h1,    1'b0, 32'h0},
    '{1'b1, A_SVC, 2'd2, 32'h1234, 1'b0, 32'h0},
    '{1'b0, A_SVC, 2'd2, 32'h0,    1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [13:0] a, input logic [1:0] sz, input logic [31:0] d);
    req = 1; we = w; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    s_err = err; s_rst = rstreq; s_rd = rdata;
    if (!rvalid) chk("R2 rvalid", 1'b0, 0, 1);
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d); bus(1'b1, a, 2'd2, d); endtask
  task automatic rd(input logic [13:0] a); bus(1'b0, a, 2'd2, 32'h0); endtask

  task automatic measure(input int max, output int first_rst, output int first_irq);
    first_rst = 0; first_irq = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (rstreq && first_rst == 0) first_rst = i;
      if (irq && first_irq == 0) first_irq = i;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int fr, fi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", irq == 0, irq, 0);
    chk("R1 rst_req_o", rstreq == 0, rstreq, 0);
    rd(A_CTRL); chk("R1 ctrl", s_rd == 0 && !s_err, s_rd, 0);
    rd(A_TO);   chk("R1 timeout", s_rd == TO_RST, s_rd, TO_RST);
    rd(A_CNT);  chk("R1 count", s_rd == TO_RST, s_rd, TO_RST);

    // R2 R3 R5 vector table
    for (int k = 0; k < NV; k++) begin
      bus(VEC[k].w, VEC[k].a, VEC[k].sz, VEC[k].d);
      chk($sformatf("R3 err vec%0d", k), s_err == VEC[k].e, s_err, VEC[k].e);
      if (!VEC[k].w) chk($sformatf("R2 rdata vec%0d", k), s_rd == VEC[k].rd, s_rd, VEC[k].rd);
    end
    // R3 permission
    perm = 0; wr(A_WIN, 32'h55); perm = 1;
    chk("R3 no-permission err", s_err == 1, s_err, 1);
    rd(A_WIN); chk("R3 no-permission dropped", s_rd == 32'hA, s_rd, 32'hA);

    // R4 reset on invalid
    wr(A_CTRL, 32'h80);
    rd(14'h18);
    chk("R4 no err", s_err == 0, s_err, 0);
    chk("R4 rst pulse", s_rst == 1, s_rst, 1);
    @(negedge clk); chk("R4 one cycle", rstreq == 0, rstreq, 0);
    wr(A_CTRL, 32'h0);

    // R5 R6 period, reset-only mode
    wr(A_TO, 32'd20);
    wr(A_CTRL, 32'h01);
    measure(25, fr, fi);
    chk("R5 R6 expiry cycle", fr == 21, fr, 21);
    chk("R6 no irq", fi == 0, fi, 0);
    wr(A_CTRL, 32'h0);

    // R7 interrupt then reset
    wr(A_CTRL, 32'h21);
    measure(45, fr, fi);
    chk("R7 first expiry irq", fi == 21, fi, 21);
    chk("R7 second expiry rst", fr == 42, fr, 42);
    wr(A_CTRL, 32'h0);
    rd(A_IRQ); chk("R7 flag read", s_rd == 1, s_rd, 1);
    wr(A_IRQ, 32'h1);
    chk("R7 w1c", irq == 0, irq, 0);

    // R8 service reload
    wr(A_TO, 32'd40);
    wr(A_CTRL, 32'h01);
    repeat (15) @(negedge clk);
    wr(A_SVC, KA); wr(A_SVC, KB);
    chk("R8 service ok", s_err == 0, s_err, 0);
    measure(45, fr, fi);
    chk("R8 reload moves expiry", fr == 41, fr, 41);
    wr(A_SVC, 32'h1234);
    chk("R8 bad key while enabled", s_err == 1, s_err, 1);
    wr(A_CTRL, 32'h0);

    // R9 window
    wr(A_TO, 32'd30); wr(A_WIN, 32'd10);
    wr(A_CTRL, 32'h41);
    wr(A_SVC, KA); wr(A_SVC, KB);
    chk("R9 early service err", s_err == 1, s_err, 1);
    repeat (20) @(negedge clk);
    wr(A_SVC, KA); wr(A_SVC, KB);
    chk("R9 late service ok", s_err == 0, s_err, 0);
    measure(35, fr, fi);
    chk("R9 late service reloads", fr == 31, fr, 31);
    wr(A_CTRL, 32'h0);

    // R10 freeze in debug
    wr(A_TO, 32'd20);
    dbg = 1;
    wr(A_CTRL, 32'h03);
    measure(60, fr, fi);
    chk("R10 debug hold no rst", fr == 0, fr, 0);
    rd(A_CNT); chk("R10 debug hold count", s_rd == 20, s_rd, 20);
    dbg = 0;
    measure(25, fr, fi);
    chk("R10 runs after debug", fr == 21, fr, 21);
    wr(A_CTRL, 32'h0);
    // R10 stop
    stp = 1;
    wr(A_CTRL, 32'h05);
    measure(40, fr, fi);
    chk("R10 stop hold", fr == 0, fr, 0);
    wr(A_CTRL, 32'h01);
    measure(25, fr, fi);
    chk("R10 stop runs with bit clear", fr == 21, fr, 21);
    wr(A_CTRL, 32'h0); stp = 0;
    // R10 standby
    sby = 1;
    wr(A_CTRL, 32'h01);
    measure(40, fr, fi);
    chk("R10 standby off", fr == 0, fr, 0);
    wr(A_CTRL, 32'h0); sby = 0;

    // R11 soft lock
    wr(A_CTRL, 32'h08);
    wr(A_TO, 32'd55); chk("R11 locked timeout err", s_err == 1, s_err, 1);
    rd(A_TO); chk("R11 timeout kept", s_rd == 20, s_rd, 20);
    wr(A_CTRL, 32'h0); chk("R11 locked ctrl err", s_err == 1, s_err, 1);
    wr(A_SVC, UA); wr(A_SVC, UB);
    rd(A_CTRL); chk("R11 unlock clears", s_rd == 0, s_rd, 0);
    wr(A_TO, 32'd55); chk("R11 writable again", s_err == 0, s_err, 0);

    // R12 hard lock
    wr(A_CTRL, 32'h10);
    wr(A_SVC, UA); wr(A_SVC, UB);
    rd(A_CTRL); chk("R12 hard lock kept", s_rd == 32'h10, s_rd, 32'h10);
    wr(A_WIN, 32'd3); chk("R12 locked window err", s_err == 1, s_err, 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(A_CTRL); chk("R12 reset clears", s_rd == 0, s_rd, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule